// File: doc/BRIEF.md
# Convert-Start Pulse and Power-Mode Controller

This block turns a single external start pin into a timed conversion cycle for a sampling converter. A rising edge on the pin that arrives while no conversion is running powers the converter up and fires an internal power-up pulse of fixed length. The pin and that pulse are ORed into a gated start. The conversion begins when the gated start falls, so the sampling instant is whichever comes later: the pin falling or the power-up pulse ending.

While a conversion runs, the block holds the busy and hold outputs high for a fixed number of clock cycles. When the conversion ends it sends out a one-cycle end-of-conversion strobe for latching the result. At the same moment it reads the pin to choose a power mode. If the pin is high, the converter stays powered (mode 1). If the pin is low, the converter powers down until the next accepted rising edge (mode 2). A rising edge that arrives during a conversion does not start anything and raises a one-cycle overrun flag.

All durations are counted in clock cycles and set by parameters. The pin must already be synchronous to `clk`. All pins are plain control and status signals. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `conv_start_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `busy_o`, `hold_o`, `eoc_o`, `overrun_o` and `pwr_en_o` are all 0. The block starts out powered down.
- R2: A rising edge on `start_i` seen while `busy_o` is 0 is accepted. It raises `pwr_en_o` in the next cycle and starts an internal power-up pulse lasting `PWRUP_CYCLES` cycles.
- R3: After an accepted edge at clock edge 0, suppose the pin stays high for H cycles. Then `busy_o` is first high in the cycle after clock edge max(`PWRUP_CYCLES`+1, H). This is the later of the pulse end and the pin fall.
- R4: `busy_o` stays high for exactly `CONV_CYCLES` consecutive cycles per conversion. `hold_o` has the same value as `busy_o` in every cycle.
- R5: `eoc_o` is high for exactly one cycle, the first cycle in which `busy_o` is low again after a conversion.
- R6: If `start_i` is 0 in the last busy cycle, mode 2 is chosen. `pwr_en_o` then goes to 0 one cycle after the cycle in which `eoc_o` is high.
- R7: If `start_i` is 1 in the last busy cycle, mode 1 is chosen and `pwr_en_o` stays 1.
- R8: While already powered in mode 1, an accepted rising edge still fires the full power-up pulse. The conversion start follows the same rule as in R3.
- R9: A rising edge on `start_i` while `busy_o` is 1 starts no pulse and no conversion. `overrun_o` is high for one cycle, in the cycle after that edge.
- R10: A fall of the gated start that was not preceded by an accepted rising edge starts no conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | External convert-start pin, synchronous to clk |
| busy_o | output | 1 | High while a conversion runs |
| hold_o | output | 1 | Sampler control: 1 = hold, 0 = track |
| pwr_en_o | output | 1 | Converter power enable |
| eoc_o | output | 1 | One-cycle end-of-conversion strobe |
| overrun_o | output | 1 | One-cycle flag for a start edge seen during a conversion |

## Verification
The bench varies how long the pin stays high: shorter than the power-up pulse, equal to it, one cycle past it, and far past it. A design that started on the pin fall alone, or on the pulse end alone, would move the busy rise off the max rule. In some runs the pin is raised again during busy, which checks the overrun flag and mode 1. Those runs then drop the pin while the block is not armed. A design that reacted to any gated-start fall would start a stray conversion there. It is also checked that power stays on after mode 1 and drops exactly one cycle after the strobe in mode 2. A reset in the middle of a conversion must clear everything at once.

// File: rtl/cs_pkg.sv
package cs_pkg;
  typedef enum logic {
    PWR_KEEP = 1'b0,
    PWR_DOWN = 1'b1
  } pwr_mode_e;
endpackage

// File: rtl/cs_timer.sv
module cs_timer #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active,
  output logic last
);
  localparam int unsigned CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b0;
    end else if (load) begin
      cnt    <= CW'(LEN - 1);
      active <= 1'b1;
    end else if (active) begin
      if (cnt == '0) active <= 1'b0;
      else           cnt    <= cnt - 1'b1;
    end
  end

  assign last = active && (cnt == '0);
endmodule

// File: rtl/cs_gate.sv
module cs_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pulse,
  output logic rise,
  output logic gfall
);
  logic pin_q, gated_q, gated;

  assign gated = pin | pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q   <= 1'b0;
      gated_q <= 1'b0;
    end else begin
      pin_q   <= pin;
      gated_q <= gated;
    end
  end

  assign rise  = pin & ~pin_q;
  assign gfall = gated_q & ~gated;
endmodule

// File: rtl/cs_power.sv
module cs_power
  import cs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic conv_last,
  input  logic eoc,
  input  logic pin,
  output logic pwr_en
);
  pwr_mode_e mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= PWR_DOWN;
      pwr_en <= 1'b0;
    end else begin
      if (conv_last) mode_q <= pin ? PWR_KEEP : PWR_DOWN;
      if (accept)                          pwr_en <= 1'b1;
      else if (eoc && mode_q == PWR_DOWN)  pwr_en <= 1'b0;
    end
  end
endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl #(
  parameter int unsigned PWRUP_CYCLES = 150,
  parameter int unsigned CONV_CYCLES  = 230
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic hold_o,
  output logic pwr_en_o,
  output logic eoc_o,
  output logic overrun_o
);
  logic rise, gfall, accept, start_conv;
  logic pulse_act, pulse_last, conv_last, armed;

  cs_gate u_gate (
    .clk(clk), .rst_n(rst_n), .pin(start_i), .pulse(pulse_act),
    .rise(rise), .gfall(gfall)
  );

  assign accept     = rise & ~busy_o;
  assign start_conv = armed & gfall & ~busy_o;

  cs_timer #(.LEN(PWRUP_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_n), .load(accept),
    .active(pulse_act), .last(pulse_last)
  );

  cs_timer #(.LEN(CONV_CYCLES)) u_conv (
    .clk(clk), .rst_n(rst_n), .load(start_conv),
    .active(busy_o), .last(conv_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      hold_o    <= 1'b0;
      eoc_o     <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (accept)          armed <= 1'b1;
      else if (start_conv) armed <= 1'b0;
      if (start_conv)      hold_o <= 1'b1;
      else if (conv_last)  hold_o <= 1'b0;
      eoc_o     <= conv_last;
      overrun_o <= rise & busy_o;
    end
  end

  cs_power u_pwr (
    .clk(clk), .rst_n(rst_n), .accept(accept), .conv_last(conv_last),
    .eoc(eoc_o), .pin(start_i), .pwr_en(pwr_en_o)
  );
endmodule

// File: rtl/cs_ctrl_chk.sv
module cs_ctrl_chk #(
  parameter int unsigned PWRUP_CYCLES = 150,
  parameter int unsigned CONV_CYCLES  = 230
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic hold_o,
  input logic pwr_en_o,
  input logic eoc_o,
  input logic overrun_o
);
  localparam int unsigned RW = $clog2(CONV_CYCLES + 2);
  logic [RW-1:0] run_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  p_hold_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_o == busy_o);
  p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> (run_cnt == RW'(CONV_CYCLES)));
  p_eoc_after_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> eoc_o);
  p_eoc_only_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_o |-> ($past(busy_o) && !busy_o));
  p_busy_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> pwr_en_o);
  p_pwr_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_en_o) |-> $past(eoc_o));
  p_overrun_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> ($past(busy_o) && $past(start_i)));
  p_start_needs_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(start_i));
endmodule

bind conv_start_ctrl cs_ctrl_chk #(
  .PWRUP_CYCLES(PWRUP_CYCLES), .CONV_CYCLES(CONV_CYCLES)
) u_chk (.*);

// File: tb/conv_start_ctrl_tb.sv
module conv_start_ctrl_tb;
  localparam int N = 6;
  localparam int C = 10;
  localparam int NV = 6;
  localparam int VEC_H    [NV] = '{1, 3, 2, 9, 7, 12};
  localparam bit VEC_KEEP [NV] = '{0, 1, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, hold_o, pwr_en_o, eoc_o, overrun_o;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  conv_start_ctrl #(.PWRUP_CYCLES(N), .CONV_CYCLES(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .hold_o(hold_o), .pwr_en_o(pwr_en_o), .eoc_o(eoc_o), .overrun_o(overrun_o)
  );

  task automatic chk(input bit act, input bit exp, input string req,
                     input string what, input int cyc);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0b expected %0b", req, what, cyc, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit exp_pwr;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(busy_o, 0, "R1", "busy", 0);
    chk(pwr_en_o, 0, "R1", "pwr_en", 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(hold_o | eoc_o | overrun_o, 0, "R1", "hold/eoc/overrun", 0);
    chk(pwr_en_o, 0, "R1", "pwr_en after reset", 0);
    exp_pwr = 1'b0;

    for (int v = 0; v < NV; v++) begin
      int h, s;
      bit keep, pin;
      h = VEC_H[v];
      keep = VEC_KEEP[v];
      s = (h > N + 1) ? h : N + 1;
      repeat (3) @(negedge clk);
      for (int k = 0; k <= s + C + 5; k++) begin
        bit eb, ep;
        if (k > 0) @(negedge clk);
        eb = (k >= s + 1) && (k <= s + C);
        chk(busy_o, eb, "R3", "busy", k);   // R3/R4/R8/R10 busy profile
        chk(hold_o, eb, "R4", "hold", k);
        chk(eoc_o, k == s + C + 1, "R5", "eoc", k);
        chk(overrun_o, keep && (k == s + 3), "R9", "overrun", k);
        if (k == 0) ep = exp_pwr;
        else if (k >= s + C + 2) ep = keep;
        else ep = 1'b1;
        chk(pwr_en_o, ep, keep ? "R7" : "R6", "pwr_en", k);
        pin = (k < h) || (keep && k >= s + 2 && k <= s + C);
        start_i = pin;
      end
      exp_pwr = keep;
    end

    // R10: pin rises during busy and falls afterwards; no conversion follows
    start_i = 1'b1;
    repeat (N + 3) @(negedge clk);
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o, 1, "R2", "busy before late rise", 0);
    start_i = 1'b1;
    repeat (C + 2) @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < N + 4; k++) begin
      @(negedge clk);
      chk(busy_o, 0, "R10", "busy after unarmed fall", k);
    end

    // R1: reset in the middle of a conversion
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    repeat (N + 4) @(negedge clk);
    chk(busy_o, 1, "R3", "busy before mid reset", 0);
    rst_n = 1'b0;
    #1;
    chk(busy_o | hold_o | pwr_en_o | eoc_o | overrun_o, 0, "R1", "outputs at mid reset", 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy_o | pwr_en_o, 0, "R1", "idle after reset", 0);
    finish_run();
  end
endmodule